// File: doc/BRIEF.md
# System Memory Address Decode Router

This block sits between requesters and the memory-side targets of a small system. It accepts one memory request at a time over a valid/ready handshake. Each request carries an address, a read/write flag, write data and a direction flag. The direction flag is 0 when the request travels downstream from the processor core and 1 when it travels upstream from the I/O fabric. The block decodes the address against fixed and programmable windows, forwards the request on exactly one of seven target ports, and returns a single completion to the requester on a response channel.

Routing depends on three things: the address, the direction, and a secure-boot strap. Reads of the reset vector region go either to an on-die root-of-trust ROM or to the legacy bridge that serves the boot flash, chosen by the strap. Writes to that same region land in DRAM. Upstream writes aimed at the interrupt controller window reach the interrupt port. A programmable, enable-gated 256 MB window maps to configuration space, and the block splits the offset into bus, device, function and register fields. Addresses below a programmable DRAM ceiling go to memory. Remaining downstream accesses are checked against programmable PCI resource windows. Anything left over is handed to the subtractive fabric agent and answered with Unsupported Request.

The controller is a four-state machine with these states:
- `S_IDLE`: the block accepts a request.
- `S_ISSUE`: the selected target port is driven until that target accepts.
- `S_AWAIT`: the block waits for the target's completion on non-posted accesses.
- `S_REPLY`: the response is held until the requester takes it.

The transitions are:
- `accept`: IDLE→ISSUE.
- `posted`: ISSUE→REPLY, for posted writes and unclaimed accesses.
- `nonposted`: ISSUE→AWAIT, for reads and configuration writes.
- `complete`: AWAIT→REPLY.
- `retire`: REPLY→IDLE.

Top module: `mem_route_hub`

## Requirements
- R1: A downstream read with address in FFFE0000h..FFFFFFFFh goes to port 0 (secure ROM) when `secure_boot`=1 and to port 1 (flash bridge) when `secure_boot`=0.
- R2: A downstream write in FFFE0000h..FFFFFFFFh goes to port 2 (DRAM), whatever the DRAM ceiling is.
- R3: An upstream write in FEE00000h..FEEFFFFFh goes to port 3 (interrupt controller). An upstream read of that range is not sent there.
- R4: While `cfg_en`=1, a downstream access whose address bits [31:28] equal `cfg_base` goes to port 4. `cfg_bus`=addr[27:20], `cfg_dev`=addr[19:15], `cfg_func`=addr[14:12] and `cfg_reg`=addr[11:0].
- R5: While `cfg_en`=0, no access reaches port 4, and the address falls through to the later decode stages.
- R6: A write sent to port 4 is non-posted. No response appears until `cpl_valid` is seen, and the response then carries `cpl_status` and `cpl_rdata`.
- R7: A write sent to ports 0–3 or 5 is posted. The response appears in the cycle after the target accepts, with status 00 (OK) and data 0.
- R8: An access not claimed by R1–R5 whose address is below `dram_top` goes to port 2.
- R9: A remaining downstream access that falls inside an enabled PCI window (inclusive base..limit) goes to port 5. `tgt_win` gives the lowest-numbered matching window.
- R10: An access claimed by nothing goes to port 6 (subtractive agent). After port 6 accepts, the response has status 01 (Unsupported Request) and data 0.
- R11: The decode priority is boot region, then interrupt window, then configuration window, then DRAM, then PCI windows, then subtractive.
- R12: Only one request is outstanding at a time. `req_ready` is high only when the block is idle. At most one `tgt_valid` bit is set, and it stays set until that target accepts. A response stays valid and unchanged until `rsp_ready`.
- R13: Reads wait for the target completion and return its status (00 OK or 10 target error) and its read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| secure_boot | input | 1 | Secure-boot strap |
| cfg_base | input | 4 | Configuration window base, address bits [31:28] |
| cfg_en | input | 1 | Configuration window enable |
| dram_top | input | 32 | Exclusive upper bound of low DRAM |
| win_base | input | NWIN*32 | PCI window bases, window k at bits [32k+31:32k] |
| win_limit | input | NWIN*32 | PCI window inclusive limits |
| win_en | input | NWIN | PCI window enables |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_upstream | input | 1 | 1 = from I/O fabric, 0 = from core |
| req_wdata | input | DW | Write data |
| tgt_valid | output | 7 | One-hot target select/valid |
| tgt_ready | input | 7 | Per-target accept |
| tgt_addr | output | 32 | Forwarded address |
| tgt_write | output | 1 | Forwarded write flag |
| tgt_wdata | output | DW | Forwarded write data |
| tgt_win | output | WIN_IW | Index of the PCI window that claimed the access |
| cfg_bus | output | 8 | Configuration bus number |
| cfg_dev | output | 5 | Configuration device number |
| cfg_func | output | 3 | Configuration function number |
| cfg_reg | output | 12 | Configuration register offset |
| cpl_valid | input | 1 | Completion from the active target |
| cpl_status | input | 2 | Completion status from the target |
| cpl_rdata | input | DW | Completion read data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_status | output | 2 | 00 OK, 01 Unsupported Request, 10 target error |
| rsp_rdata | output | DW | Response read data |

## Verification
A corrupted captured target shows up as a wrong one-hot `tgt_valid` one cycle after the request is accepted. A stuck or skipped controller state shows up within two cycles, as a response that arrives before a non-posted completion or never arrives at all. A wrong posting decision is visible in the cycle after the target accepts, because `rsp_valid` either rises or stays low there. The sweep covers every direction, read/write and strap combination over the whole address space and at every window edge, so a single corrupted compare bound produces a wrong port on the first address that crosses it.

// File: rtl/mrh_pkg.sv
`timescale 1ns/1ps
package mrh_pkg;
    localparam int ADDR_W    = 32;
    localparam int NUM_PORTS = 7;

    typedef enum logic [2:0] {
        PORT_ROM   = 3'd0,
        PORT_FLASH = 3'd1,
        PORT_DRAM  = 3'd2,
        PORT_IRQ   = 3'd3,
        PORT_CFG   = 3'd4,
        PORT_PCI   = 3'd5,
        PORT_SUBTR = 3'd6
    } port_e;

    typedef enum logic [1:0] {
        STAT_OK  = 2'b00,
        STAT_UR  = 2'b01,
        STAT_ERR = 2'b10
    } stat_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_AWAIT,
        S_REPLY
    } state_e;
endpackage

// File: rtl/mrh_win_match.sv
`timescale 1ns/1ps
module mrh_win_match
    import mrh_pkg::*;
#(
    parameter int NWIN   = 2,
    parameter int WIN_IW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NWIN*ADDR_W-1:0] win_base,
    input  logic [NWIN*ADDR_W-1:0] win_limit,
    input  logic [NWIN-1:0]        win_en,
    output logic                   hit,
    output logic [WIN_IW-1:0]      idx
);
    logic [NWIN-1:0] hit_vec;

    // one inclusive range comparator per programmable window
    for (genvar g = 0; g < NWIN; g++) begin : g_win
        logic [ADDR_W-1:0] lo;
        logic [ADDR_W-1:0] hi;
        assign lo         = win_base[g*ADDR_W +: ADDR_W];
        assign hi         = win_limit[g*ADDR_W +: ADDR_W];
        assign hit_vec[g] = win_en[g] && (addr >= lo) && (addr <= hi);
    end

    // lowest index wins on overlap
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = NWIN - 1; k >= 0; k--) begin
            if (hit_vec[k]) begin
                hit = 1'b1;
                idx = WIN_IW'(k);
            end
        end
    end
endmodule

// File: rtl/mrh_decoder.sv
`timescale 1ns/1ps
module mrh_decoder
    import mrh_pkg::*;
#(
    parameter int               NWIN       = 2,
    parameter int               WIN_IW     = (NWIN > 1) ? $clog2(NWIN) : 1,
    parameter logic [ADDR_W-1:0] BOOT_BASE = 32'hFFFE_0000,
    parameter int               BOOT_LOG2  = 17,
    parameter logic [ADDR_W-1:0] IRQ_BASE  = 32'hFEE0_0000,
    parameter int               IRQ_LOG2   = 20,
    parameter int               CFG_LOG2   = 28
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       write,
    input  logic                       upstream,
    input  logic                       secure_boot,
    input  logic [ADDR_W-CFG_LOG2-1:0] cfg_base,
    input  logic                       cfg_en,
    input  logic [ADDR_W-1:0]          dram_top,
    input  logic [NWIN*ADDR_W-1:0]     win_base,
    input  logic [NWIN*ADDR_W-1:0]     win_limit,
    input  logic [NWIN-1:0]            win_en,
    output port_e                      port,
    output logic [WIN_IW-1:0]          win_idx
);
    logic in_boot, in_irq, in_cfg, in_dram, pci_hit;

    assign in_boot = (addr >> BOOT_LOG2) == (BOOT_BASE >> BOOT_LOG2);
    assign in_irq  = (addr >> IRQ_LOG2) == (IRQ_BASE >> IRQ_LOG2);
    assign in_cfg  = cfg_en && (addr[ADDR_W-1:CFG_LOG2] == cfg_base);
    assign in_dram = addr < dram_top;

    mrh_win_match #(.NWIN(NWIN), .WIN_IW(WIN_IW)) u_win (
        .addr      (addr),
        .win_base  (win_base),
        .win_limit (win_limit),
        .win_en    (win_en),
        .hit       (pci_hit),
        .idx       (win_idx)
    );

    // fixed priority chain
    always_comb begin
        if (!upstream && in_boot) begin
            if (write)            port = PORT_DRAM;
            else if (secure_boot) port = PORT_ROM;
            else                  port = PORT_FLASH;
        end else if (upstream && write && in_irq) begin
            port = PORT_IRQ;
        end else if (!upstream && in_cfg) begin
            port = PORT_CFG;
        end else if (in_dram) begin
            port = PORT_DRAM;
        end else if (!upstream && pci_hit) begin
            port = PORT_PCI;
        end else begin
            port = PORT_SUBTR;
        end
    end
endmodule

// File: rtl/mrh_ctrl.sv
`timescale 1ns/1ps
module mrh_ctrl
    import mrh_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  port_e         cur_port,
    input  logic          cur_write,
    input  logic          tgt_taken,
    input  logic          cpl_valid,
    input  logic [1:0]    cpl_status,
    input  logic [DW-1:0] cpl_rdata,
    input  logic          rsp_ready,
    output logic          req_ready,
    output logic          load,
    output logic          issue,
    output logic          rsp_valid,
    output logic [1:0]    rsp_status,
    output logic [DW-1:0] rsp_rdata
);
    state_e state_q, state_d;
    logic   need_cpl;

    // reads wait unless unclaimed; writes wait only for config space
    assign need_cpl = cur_write ? (cur_port == PORT_CFG) : (cur_port != PORT_SUBTR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_ISSUE;
            S_ISSUE: if (tgt_taken) state_d = need_cpl ? S_AWAIT : S_REPLY;
            S_AWAIT: if (cpl_valid) state_d = S_REPLY;
            S_REPLY: if (rsp_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state_q == S_IDLE);
        load      = (state_q == S_IDLE) && req_valid;
        issue     = (state_q == S_ISSUE);
        rsp_valid = (state_q == S_REPLY);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_status <= STAT_OK;
            rsp_rdata  <= '0;
        end else if (state_q == S_ISSUE && tgt_taken && !need_cpl) begin
            rsp_status <= (cur_port == PORT_SUBTR) ? STAT_UR : STAT_OK;
            rsp_rdata  <= '0;
        end else if (state_q == S_AWAIT && cpl_valid) begin
            rsp_status <= cpl_status;
            rsp_rdata  <= cpl_rdata;
        end
    end
endmodule

// File: rtl/mem_route_hub.sv
`timescale 1ns/1ps
module mem_route_hub
    import mrh_pkg::*;
#(
    parameter int NWIN     = 2,
    parameter int DW       = 32,
    parameter int CFG_LOG2 = 28,
    parameter int WIN_IW   = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       secure_boot,
    input  logic [ADDR_W-CFG_LOG2-1:0] cfg_base,
    input  logic                       cfg_en,
    input  logic [ADDR_W-1:0]          dram_top,
    input  logic [NWIN*ADDR_W-1:0]     win_base,
    input  logic [NWIN*ADDR_W-1:0]     win_limit,
    input  logic [NWIN-1:0]            win_en,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_write,
    input  logic                       req_upstream,
    input  logic [DW-1:0]              req_wdata,
    output logic [NUM_PORTS-1:0]       tgt_valid,
    input  logic [NUM_PORTS-1:0]       tgt_ready,
    output logic [ADDR_W-1:0]          tgt_addr,
    output logic                       tgt_write,
    output logic [DW-1:0]              tgt_wdata,
    output logic [WIN_IW-1:0]          tgt_win,
    output logic [7:0]                 cfg_bus,
    output logic [4:0]                 cfg_dev,
    output logic [2:0]                 cfg_func,
    output logic [11:0]                cfg_reg,
    input  logic                       cpl_valid,
    input  logic [1:0]                 cpl_status,
    input  logic [DW-1:0]              cpl_rdata,
    output logic                       rsp_valid,
    input  logic                       rsp_ready,
    output logic [1:0]                 rsp_status,
    output logic [DW-1:0]              rsp_rdata
);
    port_e             dec_port, cur_port;
    logic [WIN_IW-1:0] dec_win, cur_win;
    logic [ADDR_W-1:0] cur_addr;
    logic              cur_write;
    logic [DW-1:0]     cur_wdata;
    logic              load, issue, tgt_taken;

    mrh_decoder #(.NWIN(NWIN), .WIN_IW(WIN_IW), .CFG_LOG2(CFG_LOG2)) u_dec (
        .addr        (req_addr),
        .write       (req_write),
        .upstream    (req_upstream),
        .secure_boot (secure_boot),
        .cfg_base    (cfg_base),
        .cfg_en      (cfg_en),
        .dram_top    (dram_top),
        .win_base    (win_base),
        .win_limit   (win_limit),
        .win_en      (win_en),
        .port        (dec_port),
        .win_idx     (dec_win)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_port  <= PORT_SUBTR;
            cur_win   <= '0;
            cur_addr  <= '0;
            cur_write <= 1'b0;
            cur_wdata <= '0;
        end else if (load) begin
            cur_port  <= dec_port;
            cur_win   <= dec_win;
            cur_addr  <= req_addr;
            cur_write <= req_write;
            cur_wdata <= req_wdata;
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_sel
        assign tgt_valid[g] = issue && (int'(cur_port) == g);
    end

    assign tgt_taken = |(tgt_valid & tgt_ready);
    assign tgt_addr  = cur_addr;
    assign tgt_write = cur_write;
    assign tgt_wdata = cur_wdata;
    assign tgt_win   = cur_win;
    assign cfg_bus   = cur_addr[27:20];
    assign cfg_dev   = cur_addr[19:15];
    assign cfg_func  = cur_addr[14:12];
    assign cfg_reg   = cur_addr[11:0];

    mrh_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .cur_port   (cur_port),
        .cur_write  (cur_write),
        .tgt_taken  (tgt_taken),
        .cpl_valid  (cpl_valid),
        .cpl_status (cpl_status),
        .cpl_rdata  (cpl_rdata),
        .rsp_ready  (rsp_ready),
        .req_ready  (req_ready),
        .load       (load),
        .issue      (issue),
        .rsp_valid  (rsp_valid),
        .rsp_status (rsp_status),
        .rsp_rdata  (rsp_rdata)
    );
endmodule

// File: rtl/mrh_checker.sv
`timescale 1ns/1ps
module mrh_checker
    import mrh_pkg::*;
#(
    parameter int DW = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_ready,
    input logic [NUM_PORTS-1:0] tgt_valid,
    input logic [NUM_PORTS-1:0] tgt_ready,
    input logic [ADDR_W-1:0]    tgt_addr,
    input logic                 tgt_write,
    input logic                 rsp_valid,
    input logic                 rsp_ready,
    input logic [1:0]           rsp_status,
    input logic [DW-1:0]        rsp_rdata
);
    logic posted_take, cfg_wr_take;
    assign posted_take = tgt_write && |(tgt_valid & tgt_ready & 7'b0101111);
    assign cfg_wr_take = tgt_write && tgt_valid[4] && tgt_ready[4];

    a_r12_onehot_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_valid));

    a_r12_busy_when_issuing: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid != '0) |-> !req_ready);

    a_r12_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((tgt_valid != '0) && ((tgt_valid & tgt_ready) == '0))
        |=> ($stable(tgt_valid) && $stable(tgt_addr)));

    a_r12_response_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_rdata)));

    a_r1_boot_ports_read_only: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_valid[0] || tgt_valid[1]) |-> !tgt_write);

    a_r3_irq_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid[3] |-> (tgt_write && tgt_addr[31:20] == 12'hFEE));

    a_r7_posted_reply: assert property (@(posedge clk) disable iff (!rst_n)
        posted_take |=> (rsp_valid && rsp_status == 2'b00));

    a_r6_nonposted_wait: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_take |=> !rsp_valid);

    a_r10_ur_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status == 2'b01) |-> (rsp_rdata == '0));
endmodule

bind mem_route_hub mrh_checker #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .tgt_valid  (tgt_valid),
    .tgt_ready  (tgt_ready),
    .tgt_addr   (tgt_addr),
    .tgt_write  (tgt_write),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_status (rsp_status),
    .rsp_rdata  (rsp_rdata)
);

// File: tb/tb_mem_route_hub.sv
`timescale 1ns/1ps
module tb_mem_route_hub;
    localparam int NWIN = 2;
    localparam int DW   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        secure_boot = 1'b0;
    logic [3:0]  cfg_base = 4'hE;
    logic        cfg_en = 1'b1;
    logic [31:0] dram_top = 32'h4000_0000;
    logic [63:0] win_base  = {32'h8800_0000, 32'h8000_0000};
    logic [63:0] win_limit = {32'h9FFF_FFFF, 32'h8FFF_FFFF};
    logic [1:0]  win_en = 2'b11;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_upstream = 1'b0;
    logic [31:0] req_wdata = '0;
    logic [6:0]  tgt_valid;
    logic [6:0]  tgt_ready = 7'h7F;
    logic [31:0] tgt_addr;
    logic        tgt_write;
    logic [31:0] tgt_wdata;
    logic [0:0]  tgt_win;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_func;
    logic [11:0] cfg_reg;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_status = '0;
    logic [31:0] cpl_rdata = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [1:0]  rsp_status;
    logic [31:0] rsp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int n_txn = 0;

    always #2 clk = ~clk;

    mem_route_hub #(.NWIN(NWIN), .DW(DW)) dut (.*);

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic int ref_port(input logic [31:0] a, input logic wr, input logic up);
        if (!up && a >= 32'hFFFE_0000) return wr ? 2 : (secure_boot ? 0 : 1);
        if (up && wr && a >= 32'hFEE0_0000 && a <= 32'hFEEF_FFFF) return 3;
        if (!up && cfg_en && a[31:28] == cfg_base) return 4;
        if (a < dram_top) return 2;
        if (!up) begin
            for (int w = 0; w < NWIN; w++)
                if (win_en[w] && a >= win_base[w*32 +: 32] && a <= win_limit[w*32 +: 32]) return 5;
        end
        return 6;
    endfunction

    function automatic int ref_win(input logic [31:0] a);
        for (int w = 0; w < NWIN; w++)
            if (win_en[w] && a >= win_base[w*32 +: 32] && a <= win_limit[w*32 +: 32]) return w;
        return 0;
    endfunction

    function automatic string port_req(input int p, input logic wr, input logic up, input logic [31:0] a);
        case (p)
            0, 1: return "R1";
            2:    return (!up && wr && a >= 32'hFFFE_0000) ? "R2" : "R8";
            3:    return "R3";
            4:    return "R4";
            5:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic run_txn(input logic [31:0] a, input logic wr, input logic up, input int stall, input string extra);
        int          ep;
        logic        need_wait;
        logic [1:0]  exp_st;
        logic [31:0] exp_d;
        logic [31:0] wd;
        string       rq;
        ep = ref_port(a, wr, up);
        rq = (extra != "") ? extra : port_req(ep, wr, up, a);
        wd = a ^ 32'h5A5A_00FF;
        n_txn++;
        @(negedge clk);
        chk("R12", "req_ready idle", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_upstream = up; req_wdata = wd;
        if (stall > 0) tgt_ready = 7'h00;
        @(negedge clk);
        req_valid = 1'b0;
        chk(rq, "tgt_valid", tgt_valid, 64'(7'(1) << ep));
        chk("R12", "req_ready busy", req_ready, 0);
        chk(rq, "tgt_addr", tgt_addr, a);
        chk(rq, "tgt_write", tgt_write, wr);
        if (wr) chk(rq, "tgt_wdata", tgt_wdata, wd);
        if (ep == 4) begin
            chk("R4", "cfg_bus", cfg_bus, a[27:20]);
            chk("R4", "cfg_dev", cfg_dev, a[19:15]);
            chk("R4", "cfg_func", cfg_func, a[14:12]);
            chk("R4", "cfg_reg", cfg_reg, a[11:0]);
        end
        if (ep == 5) chk("R9", "tgt_win", tgt_win, ref_win(a));
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk("R12", "stalled tgt_valid", tgt_valid, 64'(7'(1) << ep));
            chk("R12", "no early rsp", rsp_valid, 0);
        end
        tgt_ready = 7'h7F;
        @(negedge clk);
        need_wait = wr ? (ep == 4) : (ep != 6);
        if (need_wait) begin
            chk(wr ? "R6" : "R13", "rsp before cpl", rsp_valid, 0);
            chk("R12", "tgt released", tgt_valid, 0);
            exp_st = (n_txn % 3 == 0) ? 2'b10 : 2'b00;
            exp_d  = ~a;
            cpl_valid = 1'b1; cpl_status = exp_st; cpl_rdata = exp_d;
            @(negedge clk);
            cpl_valid = 1'b0;
        end else begin
            exp_st = (ep == 6) ? 2'b01 : 2'b00;
            exp_d  = '0;
        end
        rq = need_wait ? (wr ? "R6" : "R13") : ((ep == 6) ? "R10" : "R7");
        chk(rq, "rsp_valid", rsp_valid, 1);
        chk(rq, "rsp_status", rsp_status, exp_st);
        chk(rq, "rsp_rdata", rsp_rdata, exp_d);
        @(negedge clk);
        chk("R12", "rsp held", rsp_valid, 1);
        chk("R12", "status held", rsp_status, exp_st);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R12", "rsp retired", rsp_valid, 0);
        chk("R12", "idle again", req_ready, 1);
    endtask

    task automatic corners(input string tag);
        logic [31:0] pts [17] = '{32'hFFFD_FFFF, 32'hFFFE_0000, 32'hFFFF_FFFF, 32'hFEDF_FFFF,
                                  32'hFEE0_0000, 32'hFEEF_FFFF, 32'hFEF0_0000, 32'hDFFF_FFFF,
                                  32'hE000_0000, 32'hEFFF_FFFF, 32'hF000_0000, 32'h3FFF_FFFF,
                                  32'h4000_0000, 32'h87FF_FFFF, 32'h8800_0000, 32'h9FFF_FFFF,
                                  32'hA000_0000};
        for (int i = 0; i < 17; i++)
            for (int m = 0; m < 4; m++)
                run_txn(pts[i], m[0], m[1], 0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12", "reset req_ready", req_ready, 1);
        chk("R12", "reset tgt_valid", tgt_valid, 0);
        chk("R12", "reset rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        // R1 strap both ways, R3/R4/R8/R9/R10 edges
        corners("");
        secure_boot = 1'b1;
        corners("");
        // sweep of the whole space, all direction and access mixes
        for (int i = 0; i < 64; i++)
            for (int m = 0; m < 4; m++)
                run_txn((32'(i) << 26) | ((32'(i) * 32'h0004_1011) & 32'h03FF_FFFC), m[0], m[1], 0, "");
        // R5: window disabled, its addresses fall through
        cfg_en = 1'b0;
        run_txn(32'hE123_4567, 1'b0, 1'b0, 0, "R5");
        run_txn(32'hE123_4567, 1'b1, 1'b0, 0, "R5");
        dram_top = 32'hF000_0000;
        run_txn(32'hE000_0010, 1'b1, 1'b0, 0, "R5");
        // R11: config window overlapping DRAM and a PCI window
        cfg_en = 1'b1; cfg_base = 4'h8;
        run_txn(32'h8ABC_D123, 1'b0, 1'b0, 0, "R11");
        run_txn(32'h8ABC_D123, 1'b0, 1'b1, 0, "R11");
        dram_top = 32'h8400_0000; cfg_base = 4'h3;
        run_txn(32'h83FF_FFFC, 1'b0, 1'b0, 0, "R11");
        run_txn(32'h8400_0000, 1'b1, 1'b0, 0, "R11");
        win_en = 2'b10;
        run_txn(32'h8900_0000, 1'b0, 1'b0, 0, "R9");
        run_txn(32'h8500_0000, 1'b0, 1'b0, 0, "R10");
        run_txn(32'hFFFF_0000, 1'b1, 1'b0, 0, "R2");
        // R12: target back-pressure
        run_txn(32'h3000_1000, 1'b1, 1'b0, 3, "");
        run_txn(32'h9000_0000, 1'b0, 1'b0, 2, "");
        run_txn(32'hFEE0_0040, 1'b1, 1'b1, 4, "");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule